// File: doc/BRIEF.md
# Program Counter Redirect Unit

This block owns the program counter of a simple load/store processor and works out, every cycle, where execution continues. A decoder upstream hands it a small control-class code for the instruction now in hand, together with the instruction's short branch offset, its long jump offset, the value read from one source register, and a sense bit that says whether a conditional branch fires on zero or on nonzero. From these the unit forms the following address. It may be the sequential successor, a PC-relative target, or a target taken straight from the register. The program counter register loads that address on the next clock edge.

For procedure calls the unit also produces a write request for the return-address register. It carries the address of the instruction after the call and always names register 31. The write request is combinational and lasts exactly as long as the call class is presented, which in a one-instruction-per-cycle flow is a single cycle. Fetch, decode and hazard handling sit outside this block.

Top module: `pc_redirect`

## Requirements
- R1: While `rst` is high at a rising clock edge the program counter becomes 0, and `link_we` is low for as long as `rst` is high.
- R2: `flow_code` is a 3-bit class: 0 sequential, 1 conditional branch, 2 relative jump, 3 register jump, 4 relative call, 5 register call. Codes 6 and 7 behave exactly as 0. For class 0, `next_pc` is `pc_q + 4` (modulo 2^32).
- R3: A conditional branch is taken when `nz_sense` is 0 and `src_val` equals zero, or when `nz_sense` is 1 and `src_val` is nonzero. Otherwise it falls through to `pc_q + 4`.
- R4: A taken branch gives `next_pc = pc_q + 4 + sign-extended br_ofs` (bit 15 is the sign), wrapping modulo 2^32.
- R5: A relative jump gives `next_pc = pc_q + 4 + sign-extended jmp_ofs` (bit 25 is the sign), wrapping modulo 2^32.
- R6: A register jump gives `next_pc = src_val`, unchanged and unaligned.
- R7: A relative call takes the R5 target and asserts `link_we`, with `link_data = pc_q + 4` and `link_idx = 31`.
- R8: A register call takes `src_val` as the target and asserts `link_we`, with `link_data = pc_q + 4` and `link_idx = 31`.
- R9: `link_we` is low for every class other than 4 and 5, including codes 6 and 7.
- R10: Outside reset, `pc_q` after each rising edge equals the `next_pc` presented before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flow_code | input | 3 | Control class of the current instruction |
| br_ofs | input | 16 | Conditional-branch offset in bytes, two's complement |
| jmp_ofs | input | 26 | Relative jump/call offset in bytes, two's complement |
| src_val | input | 32 | Source register value: branch test operand or register target |
| nz_sense | input | 1 | 1: branch on nonzero, 0: branch on zero |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address the counter loads on the next edge |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Destination register of the return address, always 31 |
| link_data | output | 32 | Return address, `pc_q + 4` |

## Verification
The bench builds the unit with its default parameters: a 32-bit counter, a 16-bit branch offset, a 26-bit jump offset and the single shared relative adder. It sweeps all eight class codes against both sense values, a zero and a nonzero source operand, four counter bases and four offset pairs. The bases include one near the top of the address space, so that wrap-around can be seen. The offset pairs include the largest positive and most negative offsets, so sign extension is exercised at both extremes. Each combination is checked on the combinational outputs before the edge and on the loaded counter after it.

// File: rtl/pc_redirect_pkg.sv
package pc_redirect_pkg;

    localparam int DEF_PC_W   = 32;
    localparam int DEF_BR_W   = 16;
    localparam int DEF_J_W    = 26;
    localparam int DEF_IDX_W  = 5;
    localparam int DEF_LINK   = 31;
    localparam int FLOW_W     = 3;

    typedef enum logic [FLOW_W-1:0] {
        FLOW_SEQ    = 3'd0,
        FLOW_BRANCH = 3'd1,
        FLOW_JREL   = 3'd2,
        FLOW_JREG   = 3'd3,
        FLOW_CREL   = 3'd4,
        FLOW_CREG   = 3'd5
    } flow_e;

    typedef enum logic [1:0] {
        TGT_SEQ = 2'd0,
        TGT_REL = 2'd1,
        TGT_REG = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic rel_long;
        logic link;
    } route_t;

    function automatic route_t decode_flow(input logic [FLOW_W-1:0] code,
                                           input logic take);
        route_t r;
        r.tgt      = TGT_SEQ;
        r.rel_long = 1'b0;
        r.link     = 1'b0;
        case (code)
            FLOW_BRANCH: r.tgt = take ? TGT_REL : TGT_SEQ;
            FLOW_JREL: begin
                r.tgt      = TGT_REL;
                r.rel_long = 1'b1;
            end
            FLOW_JREG: r.tgt = TGT_REG;
            FLOW_CREL: begin
                r.tgt      = TGT_REL;
                r.rel_long = 1'b1;
                r.link     = 1'b1;
            end
            FLOW_CREG: begin
                r.tgt  = TGT_REG;
                r.link = 1'b1;
            end
            default: r.tgt = TGT_SEQ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pc_redirect_cond.sv
module pc_redirect_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] src_val,
    input  logic         nz_sense,
    output logic         take
);
    logic is_zero;

    always_comb begin
        is_zero = (src_val == '0);
        take    = nz_sense ? ~is_zero : is_zero;
    end
endmodule

// File: rtl/pc_redirect_targets.sv
module pc_redirect_targets #(
    parameter int PC_W         = 32,
    parameter int BR_W         = 16,
    parameter int J_W          = 26,
    parameter bit SHARE_ADDER  = 1'b1
) (
    input  logic [PC_W-1:0] pc,
    input  logic [BR_W-1:0] br_ofs,
    input  logic [J_W-1:0]  jmp_ofs,
    input  logic            use_long,
    output logic [PC_W-1:0] seq_pc,
    output logic [PC_W-1:0] rel_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [PC_W-1:0] br_ext;
    logic [PC_W-1:0] j_ext;

    always_comb begin
        br_ext = {{(PC_W-BR_W){br_ofs[BR_W-1]}}, br_ofs};
        j_ext  = {{(PC_W-J_W){jmp_ofs[J_W-1]}}, jmp_ofs};
        seq_pc = pc + STEP;
    end

    generate
        if (SHARE_ADDER) begin : g_shared
            logic [PC_W-1:0] ofs_sel;
            always_comb begin
                ofs_sel = use_long ? j_ext : br_ext;
                rel_pc  = seq_pc + ofs_sel;
            end
        end else begin : g_split
            logic [PC_W-1:0] br_tgt;
            logic [PC_W-1:0] j_tgt;
            always_comb begin
                br_tgt = seq_pc + br_ext;
                j_tgt  = seq_pc + j_ext;
                rel_pc = use_long ? j_tgt : br_tgt;
            end
        end
    endgenerate
endmodule

// File: rtl/pc_redirect.sv
module pc_redirect
    import pc_redirect_pkg::*;
#(
    parameter int PC_W        = DEF_PC_W,
    parameter int BR_W        = DEF_BR_W,
    parameter int J_W         = DEF_J_W,
    parameter int IDX_W       = DEF_IDX_W,
    parameter int LINK_REG    = DEF_LINK,
    parameter bit SHARE_ADDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLOW_W-1:0] flow_code,
    input  logic [BR_W-1:0]   br_ofs,
    input  logic [J_W-1:0]    jmp_ofs,
    input  logic [PC_W-1:0]   src_val,
    input  logic              nz_sense,
    output logic [PC_W-1:0]   pc_q,
    output logic [PC_W-1:0]   next_pc,
    output logic              link_we,
    output logic [IDX_W-1:0]  link_idx,
    output logic [PC_W-1:0]   link_data
);
    localparam logic [PC_W-1:0]  STEP     = PC_W'(4);
    localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);

    logic            take;
    route_t          route;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] rel_pc;

    pc_redirect_cond #(.W(PC_W)) u_cond (
        .src_val  (src_val),
        .nz_sense (nz_sense),
        .take     (take)
    );

    always_comb route = decode_flow(flow_code, take);

    pc_redirect_targets #(
        .PC_W        (PC_W),
        .BR_W        (BR_W),
        .J_W         (J_W),
        .SHARE_ADDER (SHARE_ADDER)
    ) u_tgt (
        .pc       (pc_q),
        .br_ofs   (br_ofs),
        .jmp_ofs  (jmp_ofs),
        .use_long (route.rel_long),
        .seq_pc   (seq_pc),
        .rel_pc   (rel_pc)
    );

    always_comb begin
        case (route.tgt)
            TGT_REL: next_pc = rel_pc;
            TGT_REG: next_pc = src_val;
            default: next_pc = seq_pc;
        endcase
        link_we   = route.link & ~rst;
        link_data = seq_pc;
        link_idx  = LINK_IDX;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= next_pc;
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (flow_code == FLOW_SEQ) |=> (pc_q == $past(pc_q) + STEP)); // R2

    AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        (flow_code == FLOW_BRANCH && !nz_sense && src_val != '0)
        |=> (pc_q == $past(pc_q) + STEP)); // R3

    AST_REG_TARGET: assert property (@(posedge clk) disable iff (rst)
        (flow_code == FLOW_JREG || flow_code == FLOW_CREG)
        |=> (pc_q == $past(src_val))); // R6

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_data == pc_q + STEP && link_idx == LINK_IDX)); // R7

    AST_LINK_CALLS_ONLY: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (flow_code == FLOW_CREL || flow_code == FLOW_CREG)); // R9

    AST_PC_LOADS_NEXT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc_q == $past(next_pc))); // R10
endmodule

// File: tb/test_pc_redirect.sv
module test_pc_redirect;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  flow_code = 3'd0;
    logic [15:0] br_ofs = '0;
    logic [25:0] jmp_ofs = '0;
    logic [31:0] src_val = '0;
    logic        nz_sense = 1'b0;
    logic [31:0] pc_q, next_pc, link_data;
    logic        link_we;
    logic [4:0]  link_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pc_redirect i_pc_redirect (
        .clk (clk), .rst (rst), .flow_code (flow_code), .br_ofs (br_ofs),
        .jmp_ofs (jmp_ofs), .src_val (src_val), .nz_sense (nz_sense),
        .pc_q (pc_q), .next_pc (next_pc), .link_we (link_we),
        .link_idx (link_idx), .link_data (link_data)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int cls, input bit tk);
        case (cls)
            1: return tk ? "R4 taken branch" : "R3 branch fall-through";
            2: return "R5 relative jump";
            3: return "R6 register jump";
            4: return "R7 relative call";
            5: return "R8 register call";
            default: return "R2 sequential";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pcs [4];
        logic [15:0] brs [4];
        logic [25:0] jms [4];
        logic [31:0] srcs [2];
        pcs  = '{32'h0000_0000, 32'h0000_1000, 32'hFFFF_FFF0, 32'h8000_0000};
        brs  = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFC};
        jms  = '{26'h000_0000, 26'h1FF_FFFF, 26'h200_0000, 26'h3FF_FFFC};
        srcs = '{32'h0000_0000, 32'h1234_5679};

        // R1: reset with a call class present
        flow_code = 3'd4;
        jmp_ofs = 26'h100;
        @(posedge clk); #1;
        chk(link_we == 1'b0, "R1 link_we in reset", {31'd0, link_we}, 32'd0);
        @(posedge clk); #1;
        chk(pc_q == 32'd0, "R1 pc after reset", pc_q, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int p = 0; p < 4; p++)
        for (int o = 0; o < 4; o++)
        for (int s = 0; s < 2; s++)
        for (int sn = 0; sn < 2; sn++)
        for (int c = 0; c < 8; c++) begin
            logic [31:0] base, seq, exp_next, br_t, j_t;
            bit tk, lnk;
            // load base through a register jump
            flow_code = 3'd3;
            src_val = pcs[p];
            @(posedge clk); #1;
            chk(pc_q == pcs[p], "R6 base load", pc_q, pcs[p]);
            @(negedge clk);
            base = pcs[p];
            flow_code = 3'(c);
            br_ofs = brs[o];
            jmp_ofs = jms[o];
            src_val = srcs[s];
            nz_sense = sn[0];
            seq  = base + 32'd4;
            br_t = seq + {{16{brs[o][15]}}, brs[o]};
            j_t  = seq + {{6{jms[o][25]}}, jms[o]};
            tk   = sn[0] ? (srcs[s] != 0) : (srcs[s] == 0);
            lnk  = (c == 4) || (c == 5);
            case (c)
                1: exp_next = tk ? br_t : seq;
                2, 4: exp_next = j_t;
                3, 5: exp_next = srcs[s];
                default: exp_next = seq;
            endcase
            #1;
            chk(next_pc == exp_next, tag_of(c, tk), next_pc, exp_next);
            chk(link_we == lnk, lnk ? tag_of(c, tk) : "R9 no link",
                {31'd0, link_we}, {31'd0, lnk});
            if (lnk) begin
                chk(link_data == seq, tag_of(c, tk), link_data, seq);
                chk(link_idx == 5'd31, tag_of(c, tk), {27'd0, link_idx}, 32'd31);
            end
            @(posedge clk); #1;
            chk(pc_q == exp_next, "R10 pc load", pc_q, exp_next);
            @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule